// File: doc/BRIEF.md
# Sampled Input Qualification Filter

This block cleans up a single asynchronous digital input before it feeds a consumer that reacts to edges, such as a fast shutdown path for pulse-width outputs. A short glitch on such a pin could otherwise trigger a shutdown. The raw pin is first brought into the system clock domain through a two-flop synchronizer. The synchronized level is then sampled on a strobe whose interval is set by an 8-bit period value. The qualified output moves to a new level only when a run of consecutive samples all agree on that level.

A 2-bit mode input selects one of four behaviours:
- synchronization only;
- a short qualification run;
- a long qualification run;
- an unfiltered combinational path.

The idle level after reset is high, which suits an active-low trip input. The added latency is the qualification window plus the synchronizer delay plus up to one sample interval, because the sample phase is unknown when the pin changes.

Top module: `iq_qualifier`

## Requirements
- R1: While reset is asserted and directly after it is released, `qual_o` is 1, and the synchronizer stages and the sample history are all 1.
- R2: With `mode_i` = 3, `qual_o` equals `pin_i` combinationally, with no clock delay.
- R3: With `mode_i` = 0, `qual_o` takes the value of `pin_i` exactly 3 rising clock edges after the pin changes (two synchronizer flops and one output flop).
- R4: With `period_i` = P > 0, the sample strobe fires once every 2·P clocks. With `period_i` = 0, it fires on every clock.
- R5: With `mode_i` = 1, the output changes only on a strobe, and only when the current sample and the 2 previous samples all equal the new level. Otherwise the output holds.
- R6: With `mode_i` = 2, the output changes only when the current sample and the 5 previous samples all equal the new level.
- R7: A pin pulse too short to be seen by the full run of samples (3 in mode 1, 6 in mode 2) leaves `qual_o` unchanged.
- R8: A change of `period_i` restarts the interval counter. With a new value P > 0, the first strobe comes 2·P clocks after the edge that sees the change, and no strobe fires on that edge itself.
- R9: In the sampled modes, with N samples and sample interval T clocks, the latency from a pin change to the output change is at least (N−1)·T + 3 edges and at most N·T + 2 edges. This holds up to `period_i` = 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous input |
| period_i | input | 8 | Sample period; the interval is twice this value in clocks, and 0 means every clock |
| mode_i | input | 2 | 0 synchronize only, 1 three samples, 2 six samples, 3 pass-through |
| qual_o | output | 1 | Qualified output |

## Verification
The assertions check the following on every cycle:
- in the sampled modes, the filtered level moves only on a strobe;
- a new level always matches the sample just taken;
- a sample that disagrees with the previous one never moves the output;
- consecutive strobes are never adjacent unless the period is zero;
- a period change suppresses the next strobe.

Only the bench scenarios can show the cases that need timing across many cycles:
- the exact latency in synchronize-only mode;
- the latency bounds for the three-sample and six-sample runs at short, zero and maximum periods;
- the rejection of pulses shorter than the window;
- the restart of the interval when the period changes.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC  = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_LONG  = 2'd2,
    MODE_BYPASS = 2'd3
  } qual_mode_e;
endpackage

// File: rtl/iq_sync.sv
module iq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/iq_strobe.sv
module iq_strobe #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                strobe_o
);
  localparam int CNT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] period_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    lim;
  logic                changed;

  assign changed  = (period_i != period_q);
  assign lim      = {period_q, 1'b0} - CNT_W'(1);
  assign strobe_o = !changed && ((period_q == '0) || (cnt_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (changed) begin
      period_q <= period_i;   // restart interval on new period
      cnt_q    <= '0;
    end else if (strobe_o) begin
      cnt_q    <= '0;
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q != '0) |-> (cnt_q <= lim));

  p_strobe_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && period_q != '0) |=> !strobe_o);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (changed && period_i != '0) |=> !strobe_o);
endmodule

// File: rtl/iq_filter.sv
module iq_filter
  import iq_pkg::*;
#(
  parameter int NSAMP_SHORT = 3,
  parameter int NSAMP_LONG  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sample_i,
  input  logic       strobe_i,
  input  qual_mode_e mode_i,
  output logic       qual_o
);
  localparam int HIST_W = NSAMP_LONG - 1;
  localparam logic [HIST_W-1:0] MASK_SHORT = HIST_W'((1 << (NSAMP_SHORT - 1)) - 1);
  localparam logic [HIST_W-1:0] MASK_LONG  = '1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] mask;
  logic              qual_q;
  logic              sampled;
  logic              hi_ok;
  logic              lo_ok;

  assign sampled = (mode_i == MODE_SHORT) || (mode_i == MODE_LONG);
  assign mask    = (mode_i == MODE_LONG) ? MASK_LONG : MASK_SHORT;
  assign hi_ok   =  sample_i && (&(hist_q | ~mask));
  assign lo_ok   = !sample_i && !(|(hist_q & mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '1;
      qual_q <= 1'b1;
    end else if (!sampled) begin
      qual_q <= sample_i;
    end else if (strobe_i) begin
      hist_q <= {hist_q[HIST_W-2:0], sample_i};
      if (hi_ok)      qual_q <= 1'b1;
      else if (lo_ok) qual_q <= 1'b0;
    end
  end

  assign qual_o = qual_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && !strobe_i) |=> $stable(qual_q));

  p_agree_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && strobe_i) |=> (qual_q == $past(qual_q) || qual_q == $past(sample_i)));

  p_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && strobe_i && sample_i != hist_q[0]) |=> $stable(qual_q));
endmodule

// File: rtl/iq_qualifier.sv
module iq_qualifier
  import iq_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NSAMP_SHORT = 3,
  parameter int NSAMP_LONG  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [1:0]          mode_i,
  output logic                qual_o
);
  qual_mode_e mode;
  logic       pin_sync;
  logic       strobe;
  logic       filt;

  assign mode = qual_mode_e'(mode_i);

  iq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  iq_strobe #(.PERIOD_W(PERIOD_W)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .strobe_o(strobe)
  );

  iq_filter #(.NSAMP_SHORT(NSAMP_SHORT), .NSAMP_LONG(NSAMP_LONG)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(pin_sync),
    .strobe_i(strobe),
    .mode_i  (mode),
    .qual_o  (filt)
  );

  assign qual_o = (mode == MODE_BYPASS) ? pin_i : filt;

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (filt == 1'b1));
endmodule

// File: tb/tb_iq_qualifier.sv
module tb_iq_qualifier;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b1;
  logic [7:0] period_i = 8'd2;
  logic [1:0] mode_i = 2'd0;
  logic       qual_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  iq_qualifier dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .period_i(period_i), .mode_i(mode_i), .qual_o(qual_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // pin already changed at a negedge; count rising edges until qual_o == lvl
  task automatic measure(input logic lvl, input int cap, output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (qual_o !== lvl && n < cap);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; pin_i = 1'b1; mode_i = 2'd0; period_i = 8'd2;
    wait_cyc(3);
    check(qual_o === 1'b1, "R1 in reset", int'(qual_o), 1);
    rst_ni = 1'b1;
    wait_cyc(2);
    check(qual_o === 1'b1, "R1 after release", int'(qual_o), 1);
  endtask

  task automatic t_bypass();
    mode_i = 2'd3; wait_cyc(2);
    pin_i = 1'b0; #1;
    check(qual_o === 1'b0, "R2 low passthrough", int'(qual_o), 0);
    #1 pin_i = 1'b1; #1;
    check(qual_o === 1'b1, "R2 high passthrough", int'(qual_o), 1);
    wait_cyc(1);
  endtask

  task automatic t_sync_only();
    int n;
    mode_i = 2'd0; pin_i = 1'b1; wait_cyc(5);
    pin_i = 1'b0; measure(1'b0, 50, n);
    check(n == 3, "R3 fall latency", n, 3);
    pin_i = 1'b1; measure(1'b1, 50, n);
    check(n == 3, "R3 rise latency", n, 3);
  endtask

  task automatic t_sampled(input logic [1:0] m, input logic [7:0] p, input int ns,
                           input string req);
    int n, ts, lo, hi;
    ts = (p == 0) ? 1 : 2 * int'(p);
    lo = (ns - 1) * ts + 3;
    hi = ns * ts + 2;
    mode_i = m; period_i = p; pin_i = 1'b1;
    wait_cyc(ns * ts + 10);
    pin_i = 1'b0; measure(1'b0, hi + 20, n);
    check(n >= lo && n <= hi && qual_o === 1'b0, {req, " fall latency"}, n, lo);
    wait_cyc(3);
    pin_i = 1'b1; measure(1'b1, hi + 20, n);
    check(n >= lo && n <= hi && qual_o === 1'b1, {req, " rise latency"}, n, hi);
  endtask

  task automatic t_glitch(input logic [1:0] m, input int len, input int ns);
    int bad;
    mode_i = m; period_i = 8'd2; pin_i = 1'b1;
    wait_cyc(ns * 4 + 10);
    bad = 0;
    pin_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i); if (qual_o !== 1'b1) bad++;
    end
    pin_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); if (qual_o !== 1'b1) bad++;
    end
    check(bad == 0, "R7 short pulse rejected", bad, 0);
  endtask

  task automatic t_zero_period();
    int n;
    mode_i = 2'd1; period_i = 8'd0; pin_i = 1'b1; wait_cyc(10);
    pin_i = 1'b0; measure(1'b0, 50, n);
    check(n == 5, "R4 period zero strobes every clock", n, 5);
    pin_i = 1'b1; wait_cyc(10);
  endtask

  task automatic t_restart();
    int n;
    mode_i = 2'd1; period_i = 8'd2; pin_i = 1'b1; wait_cyc(30);
    period_i = 8'd3; pin_i = 1'b0;
    measure(1'b0, 60, n);
    check(n == 19, "R8 interval restart on period change", n, 19);
    pin_i = 1'b1; wait_cyc(40);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_sync_only();
    t_sampled(2'd1, 8'd2, 3, "R5 short run");
    t_sampled(2'd2, 8'd2, 6, "R6 long run");
    t_glitch(2'd1, 6, 3);
    t_glitch(2'd2, 18, 6);
    t_zero_period();
    t_restart();
    t_sampled(2'd1, 8'd255, 3, "R9 max period");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule